// File: doc/BRIEF.md
# Scheduled Streaming Crossbar

This block is a switch that carries data streams between processing cores arranged as dataflow pipelines. Each producer core drives one of the `N_IN` stream inputs. Each consumer core is fed by one of the `N_CH` output channels. Every output channel has its own multiplexer and its own registered output stage. Backpressure uses a valid/ready handshake on both sides. Several independent pipelines can share the fabric at the same time, because each channel carries its own schedule.

Software configures each channel through a small write-only register port while `run_en` is low. A channel has four settings:
- the input it takes data from;
- a join group;
- the cycle at which it may begin;
- the number of words it passes.

With `run_en` high, a `start` pulse clears a shared cycle counter and arms every channel. A channel moves words only inside its window: from its start cycle until its word budget is used up. Channels that share a join group move in lockstep. A word passes through any member of the group only when every active member has valid input and room in its output stage at the same time. One input may feed several channels of one group, and each of those channels then receives the same word. Per-channel done flags and a global done flag show when the scheduled transfers are complete.

Top module: `stream_sched_xbar`

## Requirements
- R1: Output channel c carries the words of the input whose index is held in its select field (address `{c, 2'b00}`), in the order that input offered them.
- R2: A channel passes exactly the number of words in its count field (address `{c, 2'b11}`) after a start pulse, and then stops. The selected input is consumed exactly that many times.
- R3: The cycle counter reads 0 after the edge that samples `start` and then increments by one each cycle. A channel transfers only while the counter is at least its start field (address `{c, 2'b10}`). With valid input and ready output, out_valid first appears after the edge that follows the counter reaching the start value, which is start+2 edges counting the start-sampling edge as the first.
- R4: Channels with equal group fields (address `{c, 2'b01}`) transfer in the same cycle, and only when every active member has valid input and a free or draining output register. Channels in different groups progress independently.
- R5: A channel whose count field is 0 is disabled. Its out_valid stays low, it never blocks its group, and it is left out of the global done condition.
- R6: While out_valid is high and out_ready is low, the output word and its valid are held. With input always valid and output always ready, a channel's words leave on consecutive cycles with no bubble.
- R7: Configuration writes are ignored while `run_en` is high.
- R8: An input's ready is high only in cycles where every active channel selecting it takes the word. A word fed to two channels of one group reaches both.
- R9: `chan_done[c]` rises when an enabled, armed channel has used its whole budget and its output register is empty. `all_done` is high when every enabled channel is done.
- R10: After reset all valids, readies and done flags are low, and all channels are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global enable; low disarms and allows configuration |
| start | input | 1 | Pulse that clears the cycle counter and arms the channels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CH_W+2 | {channel, field}; field 0 select, 1 group, 2 start cycle, 3 count |
| cfg_wdata | input | CFG_W | Configuration write data |
| in_valid | input | N_IN | Per-input valid |
| in_ready | output | N_IN | Per-input ready |
| in_data | input | N_IN*DATA_W | Input words, input i in bits [i*DATA_W +: DATA_W] |
| out_valid | output | N_CH | Per-channel valid |
| out_ready | input | N_CH | Per-channel ready |
| out_data | output | N_CH*DATA_W | Output words, channel c in bits [c*DATA_W +: DATA_W] |
| chan_done | output | N_CH | Per-channel completion |
| all_done | output | 1 | All enabled channels complete |

## Verification
The bench builds the block with four inputs, four channels, 16-bit data and 8-bit cycle and count fields. With these values every channel can pick any input, and the two-bit group field can give each channel its own group or put several channels together. Start cycles up to 9 and budgets up to 7 keep each run within a few dozen cycles. This still reaches late starts, single-word budgets, stalled outputs, two-channel joins, forks from one input and a disabled channel sitting inside an active group.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  typedef enum logic [1:0] {
    FLD_SEL   = 2'd0,
    FLD_GRP   = 2'd1,
    FLD_START = 2'd2,
    FLD_COUNT = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/sxb_cfg_bank.sv
module sxb_cfg_bank #(
  parameter int N_CH   = 4,
  parameter int SEL_W  = 2,
  parameter int GRP_W  = 2,
  parameter int CYC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic                         lock,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CFG_W-1:0]             wdata,
  output logic [N_CH-1:0][SEL_W-1:0]   sel_o,
  output logic [N_CH-1:0][GRP_W-1:0]   grp_o,
  output logic [N_CH-1:0][CYC_W-1:0]   start_o,
  output logic [N_CH-1:0][CNT_W-1:0]   count_o
);
  import sxb_pkg::*;

  logic [CH_W-1:0] wr_ch;
  cfg_field_e      wr_fld;

  assign wr_ch  = addr[ADDR_W-1:2];
  assign wr_fld = cfg_field_e'(addr[1:0]);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel_r;
    logic [GRP_W-1:0] grp_r;
    logic [CYC_W-1:0] start_r;
    logic [CNT_W-1:0] count_r;
    logic             hit;

    assign hit = we && !lock && (wr_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_r   <= '0;
        grp_r   <= '0;
        start_r <= '0;
        count_r <= '0;
      end else if (hit) begin
        case (wr_fld)
          FLD_SEL:   sel_r   <= wdata[SEL_W-1:0];
          FLD_GRP:   grp_r   <= wdata[GRP_W-1:0];
          FLD_START: start_r <= wdata[CYC_W-1:0];
          default:   count_r <= wdata[CNT_W-1:0];
        endcase
      end
    end

    assign sel_o[c]   = sel_r;
    assign grp_o[c]   = grp_r;
    assign start_o[c] = start_r;
    assign count_o[c] = count_r;
  end
endmodule

// File: rtl/sxb_chan_ctrl.sv
module sxb_chan_ctrl #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             live,
  input  logic [CYC_W-1:0] cyc,
  input  logic [CYC_W-1:0] start_cfg,
  input  logic [CNT_W-1:0] count_cfg,
  input  logic             fire,
  output logic             active_o,
  output logic             enabled_o,
  output logic             spent_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)       rem_q <= '0;
    else if (arm)  rem_q <= count_cfg;
    else if (fire) rem_q <= rem_q - 1'b1;
  end

  assign enabled_o = (count_cfg != '0);
  assign spent_o   = (rem_q == '0);
  assign active_o  = live && enabled_o && !spent_o && (cyc >= start_cfg);
endmodule

// File: rtl/sxb_group_join.sv
module sxb_group_join #(
  parameter int N_CH  = 4,
  parameter int GRP_W = 2,
  localparam int N_GRP = 1 << GRP_W
) (
  input  logic [N_CH-1:0]             active,
  input  logic [N_CH-1:0]             can,
  input  logic [N_CH-1:0][GRP_W-1:0]  grp,
  output logic [N_CH-1:0]             go
);
  logic [N_GRP-1:0] blocked;

  always_comb begin
    blocked = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (active[c] && !can[c]) blocked[grp[c]] = 1'b1;
    end
    for (int c = 0; c < N_CH; c++) begin
      go[c] = active[c] && !blocked[grp[c]];
    end
  end
endmodule

// File: rtl/sxb_out_reg.sv
module sxb_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst || clr)   valid_o <= 1'b0;
    else if (load)    valid_o <= 1'b1;
    else if (ready_i) valid_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       data_o <= '0;
    else if (load) data_o <= data_i;
  end
endmodule

// File: rtl/stream_sched_xbar.sv
module stream_sched_xbar #(
  parameter int N_IN   = 4,
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  parameter int CYC_W  = 16,
  parameter int CNT_W  = 16,
  localparam int SEL_W  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int GRP_W  = CH_W,
  localparam int ADDR_W = CH_W + 2,
  localparam int CFG_W  = (CYC_W > CNT_W) ? CYC_W : CNT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_en,
  input  logic                     start,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic [N_CH-1:0]          out_valid,
  input  logic [N_CH-1:0]          out_ready,
  output logic [N_CH*DATA_W-1:0]   out_data,
  output logic [N_CH-1:0]          chan_done,
  output logic                     all_done
);
  logic [N_CH-1:0][SEL_W-1:0]  sel_q;
  logic [N_CH-1:0][GRP_W-1:0]  grp_q;
  logic [N_CH-1:0][CYC_W-1:0]  start_q;
  logic [N_CH-1:0][CNT_W-1:0]  count_q;
  logic [N_IN-1:0][DATA_W-1:0] in_vec;

  logic             armed_q;
  logic [CYC_W-1:0] cyc_q;
  logic             arm;
  logic             live;
  logic             flush;

  logic [N_CH-1:0]  act;
  logic [N_CH-1:0]  en;
  logic [N_CH-1:0]  spent;
  logic [N_CH-1:0]  can;
  logic [N_CH-1:0]  go;

  assign in_vec = in_data;
  assign arm    = run_en && start;
  assign live   = armed_q && run_en && !start;
  assign flush  = arm || !run_en;

  sxb_cfg_bank #(
    .N_CH (N_CH), .SEL_W(SEL_W), .GRP_W(GRP_W),
    .CYC_W(CYC_W), .CNT_W(CNT_W), .CFG_W(CFG_W)
  ) cfg_i (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .lock   (run_en),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .sel_o  (sel_q),
    .grp_o  (grp_q),
    .start_o(start_q),
    .count_o(count_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cyc_q   <= '0;
    end else if (!run_en) begin
      armed_q <= 1'b0;
    end else if (start) begin
      armed_q <= 1'b1;
      cyc_q   <= '0;
    end else if (armed_q && (cyc_q != '1)) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    logic src_ok;

    if (N_IN == (1 << SEL_W)) begin : g_full
      assign src_ok = 1'b1;
    end else begin : g_part
      assign src_ok = ({1'b0, sel_q[c]} < (SEL_W+1)'(N_IN));
    end

    assign can[c] = src_ok && in_valid[sel_q[c]] &&
                    (!out_valid[c] || out_ready[c]);

    sxb_chan_ctrl #(.CYC_W(CYC_W), .CNT_W(CNT_W)) ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .arm      (arm),
      .live     (live),
      .cyc      (cyc_q),
      .start_cfg(start_q[c]),
      .count_cfg(count_q[c]),
      .fire     (go[c]),
      .active_o (act[c]),
      .enabled_o(en[c]),
      .spent_o  (spent[c])
    );

    sxb_out_reg #(.DATA_W(DATA_W)) oreg_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (flush),
      .load   (go[c]),
      .data_i (in_vec[sel_q[c]]),
      .ready_i(out_ready[c]),
      .valid_o(out_valid[c]),
      .data_o (out_data[c*DATA_W +: DATA_W])
    );

    assign chan_done[c] = armed_q && en[c] && spent[c] && !out_valid[c];
  end

  sxb_group_join #(.N_CH(N_CH), .GRP_W(GRP_W)) join_i (
    .active(act),
    .can   (can),
    .grp   (grp_q),
    .go    (go)
  );

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      in_ready[i] = 1'b0;
      for (int c = 0; c < N_CH; c++) begin
        if (go[c] && (sel_q[c] == SEL_W'(i))) in_ready[i] = 1'b1;
      end
    end
  end

  assign all_done = armed_q && (&(chan_done | ~en));
endmodule

// File: rtl/sxb_checker.sv
module sxb_checker #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  parameter int CYC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int GRP_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run_en,
  input  logic                        start,
  input  logic [CYC_W-1:0]            cyc_q,
  input  logic [N_CH-1:0][CYC_W-1:0]  start_q,
  input  logic [N_CH-1:0][CNT_W-1:0]  count_q,
  input  logic [N_CH-1:0][GRP_W-1:0]  grp_q,
  input  logic [N_CH-1:0]             act,
  input  logic [N_CH-1:0]             go,
  input  logic [N_CH-1:0]             out_valid,
  input  logic [N_CH-1:0]             out_ready,
  input  logic [N_CH*DATA_W-1:0]      out_data
);
  logic arm;
  assign arm = run_en && start;

  for (genvar c = 0; c < N_CH; c++) begin : g_c
    logic [CNT_W:0] seen_q;

    always_ff @(posedge clk) begin
      if (rst || arm) seen_q <= '0;
      else if (go[c]) seen_q <= seen_q + 1'b1;
    end

    // R2: a channel never moves more words than its budget
    p_budget_r2: assert property (@(posedge clk) disable iff (rst)
      go[c] |-> (seen_q < {1'b0, count_q[c]}));

    // R3: no transfer before the programmed start cycle
    p_no_early_r3: assert property (@(posedge clk) disable iff (rst)
      go[c] |-> (cyc_q >= start_q[c]));

    // R5: a zero budget keeps the channel silent
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      (run_en && count_q[c] == '0) |-> !out_valid[c]);

    // R6: a stalled output holds its word
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid[c] && !out_ready[c] && run_en && !start) |=>
        (out_valid[c] && $stable(out_data[c*DATA_W +: DATA_W])));

    // R7: configuration frozen while running
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (rst)
      run_en |=> ($stable(count_q[c]) && $stable(start_q[c]) && $stable(grp_q[c])));

    for (genvar k = c + 1; k < N_CH; k++) begin : g_k
      // R4: active members of one group move together
      p_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
        (act[c] && act[k] && grp_q[c] == grp_q[k]) |-> (go[c] == go[k]));
    end
  end
endmodule

bind stream_sched_xbar sxb_checker #(
  .N_CH(N_CH), .DATA_W(DATA_W), .CYC_W(CYC_W), .CNT_W(CNT_W), .GRP_W(GRP_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .run_en   (run_en),
  .start    (start),
  .cyc_q    (cyc_q),
  .start_q  (start_q),
  .count_q  (count_q),
  .grp_q    (grp_q),
  .act      (act),
  .go       (go),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/stream_sched_xbar_tb_top.sv
`timescale 1ns/1ps
module stream_sched_xbar_tb_top;
  localparam int NI = 4;
  localparam int NC = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst, run_en, start, cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [NI-1:0] in_valid, in_ready, want_valid;
  logic [NI-1:0][DW-1:0] src;
  logic [NC-1:0] out_valid, out_ready, chan_done;
  logic [NC*DW-1:0] out_data;
  logic all_done;

  always #10 clk = ~clk;

  stream_sched_xbar #(.N_IN(NI), .N_CH(NC), .DATA_W(DW), .CYC_W(8), .CNT_W(8)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .start(start),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(src),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .chan_done(chan_done), .all_done(all_done)
  );

  int n_checks = 0, n_fail = 0;
  int first_n[NC], last_n[NC], nwords[NC], bad[NC], in_take[NI];
  logic [DW-1:0] exp_next[NC];
  int chsel[NC];
  logic [NI-1:0] cons;
  int ncyc;
  bit stall_en;

  // {ch[2], sel[2], start[8], count[8], stall[1]}
  localparam logic [20:0] VEC [6] = '{
    {2'd0, 2'd0, 8'd0, 8'd4, 1'b0},
    {2'd1, 2'd2, 8'd5, 8'd3, 1'b0},
    {2'd2, 2'd3, 8'd2, 8'd6, 1'b1},
    {2'd3, 2'd1, 8'd9, 8'd1, 1'b0},
    {2'd0, 2'd3, 8'd3, 8'd5, 1'b1},
    {2'd2, 2'd1, 8'd0, 8'd7, 1'b0}
  };

  function automatic logic [DW-1:0] base(int i);
    return DW'(16'h1000 * (i + 1));
  endfunction

  task automatic check(bit ok, string req, int act_v, int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic cfg(int ch, int fld, int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = {ch[1:0], fld[1:0]};
    cfg_wdata = val[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ch(int ch, int sel, int grp, int st, int cnt);
    chsel[ch] = sel;
    cfg(ch, 0, sel);
    cfg(ch, 1, grp);
    cfg(ch, 2, st);
    cfg(ch, 3, cnt);
  endtask

  task automatic clear_all();
    for (int c = 0; c < NC; c++) begin
      chsel[c] = 0;
      cfg(c, 3, 0);
    end
  endtask

  task automatic sample();
    for (int i = 0; i < NI; i++) begin
      if (cons[i]) begin
        src[i] = src[i] + 1'b1;
        in_take[i]++;
      end
    end
    in_valid = want_valid;
    out_ready = (stall_en && (ncyc % 3 == 0)) ? '0 : '1;
    #1;
    for (int c = 0; c < NC; c++) begin
      if (out_valid[c] && first_n[c] < 0) first_n[c] = ncyc;
      if (out_valid[c] && out_ready[c]) begin
        last_n[c] = ncyc;
        if (out_data[c*DW +: DW] != exp_next[c]) bad[c]++;
        exp_next[c] = exp_next[c] + 1'b1;
        nwords[c]++;
      end
    end
    cons = in_valid & in_ready;
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ncyc++;
      sample();
    end
  endtask

  task automatic begin_run();
    for (int c = 0; c < NC; c++) begin
      first_n[c] = -1; last_n[c] = -1; nwords[c] = 0; bad[c] = 0;
      exp_next[c] = base(chsel[c]);
    end
    for (int i = 0; i < NI; i++) begin
      src[i] = base(i);
      in_take[i] = 0;
    end
    cons = '0;
    @(negedge clk);
    run_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 1;
    sample();
  endtask

  task automatic end_run();
    @(negedge clk);
    run_en = 1'b0;
    stall_en = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; run_en = 1'b0; start = 1'b0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; want_valid = '1; in_valid = '1;
    out_ready = '1; stall_en = 1'b0; cons = '0; ncyc = 0;
    for (int i = 0; i < NI; i++) src[i] = base(i);
    for (int c = 0; c < NC; c++) chsel[c] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == '0, "R10 out_valid", int'(out_valid), 0);
    check(in_ready == '0, "R10 in_ready", int'(in_ready), 0);
    check(chan_done == '0, "R10 chan_done", int'(chan_done), 0);
    check(all_done == 1'b0, "R10 all_done", int'(all_done), 0);
    rst = 1'b0;

    // Vector table: R1 routing, R2 budget, R3 start, R6 no bubble
    for (int v = 0; v < 6; v++) begin
      int ch, sel, st, cnt;
      ch = int'(VEC[v][20:19]); sel = int'(VEC[v][18:17]);
      st = int'(VEC[v][16:9]);  cnt = int'(VEC[v][8:1]);
      clear_all();
      set_ch(ch, sel, 0, st, cnt);
      want_valid = '1;
      stall_en = VEC[v][0];
      begin_run();
      step(39);
      check(first_n[ch] == st + 2, "R3 first valid cycle", first_n[ch], st + 2);
      check(nwords[ch] == cnt, "R2 words delivered", nwords[ch], cnt);
      check(in_take[sel] == cnt, "R2 input consumed", in_take[sel], cnt);
      check(bad[ch] == 0, "R1 routed data", bad[ch], 0);
      if (!VEC[v][0])
        check(last_n[ch] == st + 1 + cnt, "R6 back-to-back", last_n[ch], st + 1 + cnt);
      end_run();
    end

    // R4: join blocks until every member has input
    clear_all();
    set_ch(0, 0, 1, 0, 4);
    set_ch(1, 1, 1, 0, 4);
    want_valid = 4'b1101;
    begin_run();
    step(9);
    check(nwords[0] == 0 && first_n[0] == -1, "R4 join holds member", nwords[0], 0);
    check(in_take[0] == 0, "R4 join holds input", in_take[0], 0);
    want_valid = '1;
    step(15);
    check(nwords[0] == 4 && nwords[1] == 4, "R4 join completes", nwords[0] + nwords[1], 8);
    check(first_n[0] == first_n[1], "R4 lockstep first word", first_n[0], first_n[1]);
    end_run();

    // R4: separate groups progress independently
    clear_all();
    set_ch(0, 0, 0, 0, 3);
    set_ch(1, 1, 1, 0, 3);
    want_valid = 4'b1101;
    begin_run();
    step(15);
    check(nwords[0] == 3, "R4 free group proceeds", nwords[0], 3);
    check(nwords[1] == 0, "R4 starved group waits", nwords[1], 0);
    end_run();
    want_valid = '1;

    // R5 + R9: disabled member inside an active group
    clear_all();
    set_ch(0, 2, 0, 0, 0);
    set_ch(1, 2, 0, 0, 3);
    begin_run();
    step(15);
    check(first_n[0] == -1, "R5 disabled stays silent", first_n[0], -1);
    check(nwords[1] == 3, "R5 group not blocked", nwords[1], 3);
    check(chan_done[0] == 1'b0, "R5 disabled not done", int'(chan_done[0]), 0);
    check(all_done == 1'b1, "R9 all_done ignores disabled", int'(all_done), 1);
    end_run();

    // R8: fork of one input into two channels, with stalls
    clear_all();
    set_ch(2, 1, 2, 0, 5);
    set_ch(3, 1, 2, 0, 5);
    stall_en = 1'b1;
    begin_run();
    step(25);
    check(nwords[2] == 5 && nwords[3] == 5, "R8 both branches", nwords[2] + nwords[3], 10);
    check(bad[2] == 0 && bad[3] == 0, "R8 same words", bad[2] + bad[3], 0);
    check(in_take[1] == 5, "R8 input taken once per word", in_take[1], 5);
    end_run();

    // R9: done timing
    clear_all();
    set_ch(0, 0, 0, 4, 6);
    begin_run();
    step(2);
    check(all_done == 1'b0 && chan_done[0] == 1'b0, "R9 not done early", int'(all_done), 0);
    step(8);
    check(chan_done[0] == 1'b0, "R9 not done with word pending", int'(chan_done[0]), 0);
    step(1);
    check(chan_done[0] == 1'b1, "R9 chan_done after last word", int'(chan_done[0]), 1);
    check(all_done == 1'b1, "R9 all_done", int'(all_done), 1);
    end_run();

    // R7: writes while running are dropped
    clear_all();
    set_ch(0, 0, 0, 0, 2);
    begin_run();
    step(8);
    cfg(0, 3, 9);
    begin_run();
    step(20);
    check(nwords[0] == 2, "R7 budget unchanged", nwords[0], 2);
    end_run();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule